// File: doc/BRIEF.md
# Pulse-Width Single-Wire Slave Transceiver

This block is the slave end of a single-wire bus that carries data as pulse widths. The master starts every bit slot by pulling the line low. The slave never sets slot timing by itself. Each master falling edge restarts a small local time base, and that time base then places three events. The first is the point where a written bit is read. The second is the end of the slave's own drive window on a read slot. The third is an inactivity timeout that marks a frame boundary. The slave returns data by enabling an open-drain pull-down on the shared, wired line. The line is high whenever no device pulls it low.

The local time base runs only while the bus is active, and it stops once the timeout has been reached. A prescaler divided from `clk` stands in for a gated oscillator that runs at about four ticks per slot. The slot position is kept in a Gray-coded counter of `CNT_W` bits. That one counter provides the sample point at count `SAMPLE_AT` and the timeout at its all-ones count. The sample point sits near the middle of a nominal slot, so the master's slot length may vary widely and bits are still read correctly. Byte assembly, command decoding and the master are outside this block.

With the default parameters, one tick is `TICK_DIV`=4 cycles, the sample point is count 2 (cycle 8 of the slot), and the timeout is count 7 (cycle 28 of the slot).

Top module: `pwmSlave`

## Requirements
- R1: While `rstN` is low, and afterwards while the line stays high, `pullDown`, `rxValid`, `frameStart` and `rxBit` are all 0.
- R2: `lineIn` passes through two synchronizing flops. A high-to-low change of the synchronized line starts a slot. The slot-start cycle is the third rising clock edge after `lineIn` falls. Every later event of the slot is timed from that cycle, in units of `TICK_DIV` cycles counted by a Gray-coded counter.
- R3: On a write slot (`txEn`=0 at slot start), `rxValid` pulses high for exactly one cycle, `SAMPLE_AT*TICK_DIV` cycles after slot start. In that same cycle `rxBit` holds the synchronized line level, with 1 meaning high. `rxValid` and `frameStart` are never high together.
- R4: On a read slot returning 0 (`txEn`=1, `txBit`=0 at slot start), `pullDown` is high from the slot-start cycle for exactly `SAMPLE_AT*TICK_DIV` cycles. No `rxValid` pulse occurs.
- R5: On a read slot returning 1 (`txEn`=1, `txBit`=1 at slot start), `pullDown` stays 0 for the whole slot. No `rxValid` pulse occurs.
- R6: `txEn` and `txBit` are read only in the slot-start cycle. Changing them later in the slot has no effect on `pullDown` or `rxValid`.
- R7: When no new slot starts for `(2**CNT_W-1)*TICK_DIV` cycles after a slot start, `frameStart` pulses for one cycle at exactly that cycle. The counter then stops, so a quiet line yields exactly one pulse.
- R8: If a slot start falls in the same cycle as the timeout, the slot start wins. No `frameStart` pulse occurs, and the counter restarts from zero.
- R9: A falling edge on the synchronized line is ignored while `pullDown` is high. It neither restarts the slot nor shifts any of the slot's events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the prescaler and all registers |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Level of the shared bus line (asynchronous) |
| txEn | input | 1 | 1 marks the coming slot as a read slot answered by this slave |
| txBit | input | 1 | Bit returned on a read slot |
| pullDown | output | 1 | Enable of the open-drain pull-down on the line |
| rxBit | output | 1 | Last bit received on a write slot |
| rxValid | output | 1 | One-cycle strobe when `rxBit` is updated |
| frameStart | output | 1 | One-cycle strobe at the inactivity timeout (frame boundary) |

## Verification
Two events can fall in the same cycle, and the bench provokes each on purpose.

The first pairing is a new slot start and the inactivity timeout. The bench spaces two master edges exactly 28 cycles apart. It then checks that no `frameStart` pulse appears in either slot, and that the second slot still samples at its own offset.

The second pairing is a line edge and the slave's own drive window. During a read-0 slot, the bench forces a high-then-low glitch on the line. It then checks that the pull-down length and the timeout cycle are unchanged.

// File: rtl/pwmSlavePkg.sv
package pwmSlavePkg;

  // Strobes from the slot control to the datapath; at most one is high per cycle.
  typedef struct packed {
    logic slotStart;  // master falling edge accepted, slot restarts
    logic samplePt;   // counter reaches the sample count
    logic timeout;    // counter reaches its all-ones count
  } slotStrb_t;

endpackage

// File: rtl/pwmSlaveCtrl.sv
module pwmSlaveCtrl
  import pwmSlavePkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int TICK_DIV  = 4,
  parameter int SAMPLE_AT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             pullDown,
  output slotStrb_t        strb,
  output logic             lineSync,
  output logic [CNT_W-1:0] grayCnt
);

  localparam int PRE_W = (TICK_DIV < 2) ? 1 : $clog2(TICK_DIV);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_SAMPLE = CNT_W'(SAMPLE_AT);

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [CNT_W-1:0] binToGray(input logic [CNT_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [2:0]       syncQ;     // [0],[1] synchronizer, [2] previous level
  logic             running;
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] grayQ;
  logic [CNT_W-1:0] binNext;
  logic             fallEdge;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[1:0], lineIn};
  end

  assign lineSync = syncQ[1];
  assign fallEdge = syncQ[2] & ~syncQ[1] & ~pullDown;
  assign tick     = running && (preCnt == PRE_LAST);
  assign binNext  = grayToBin(grayQ) + 1'b1;

  always_comb begin
    strb.slotStart = fallEdge;
    strb.samplePt  = !fallEdge && tick && (binNext == CNT_SAMPLE);
    strb.timeout   = !fallEdge && tick && (binNext == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      preCnt  <= '0;
      grayQ   <= binToGray(CNT_MAX);
    end else if (fallEdge) begin
      running <= 1'b1;
      preCnt  <= '0;
      grayQ   <= '0;
    end else if (running) begin
      if (tick) begin
        preCnt <= '0;
        grayQ  <= binToGray(binNext);
        if (binNext == CNT_MAX) running <= 1'b0;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  assign grayCnt = grayQ;

endmodule

// File: rtl/pwmSlaveData.sv
module pwmSlaveData
  import pwmSlavePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  slotStrb_t strb,
  input  logic      lineSync,
  input  logic      txEn,
  input  logic      txBit,
  output logic      pullDown,
  output logic      rxBit,
  output logic      rxValid,
  output logic      frameStart
);

  logic readSlot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readSlot   <= 1'b0;
      pullDown   <= 1'b0;
      rxBit      <= 1'b0;
      rxValid    <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      rxValid    <= 1'b0;
      frameStart <= 1'b0;
      if (strb.slotStart) begin
        readSlot <= txEn;
        pullDown <= txEn & ~txBit;
      end else begin
        if (strb.samplePt) begin
          pullDown <= 1'b0;
          if (!readSlot) begin
            rxValid <= 1'b1;
            rxBit   <= lineSync;
          end
        end
        if (strb.timeout) frameStart <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwmSlave.sv
module pwmSlave
  import pwmSlavePkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int TICK_DIV  = 4,
  parameter int SAMPLE_AT = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  input  logic txEn,
  input  logic txBit,
  output logic pullDown,
  output logic rxBit,
  output logic rxValid,
  output logic frameStart
);

  slotStrb_t        strb;
  logic             lineSync;
  logic [CNT_W-1:0] grayCnt;
  logic             pullDownW;

  pwmSlaveCtrl #(
    .CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .SAMPLE_AT(SAMPLE_AT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .pullDown(pullDownW),
    .strb(strb), .lineSync(lineSync), .grayCnt(grayCnt)
  );

  pwmSlaveData uData (
    .clk(clk), .rstN(rstN), .strb(strb), .lineSync(lineSync),
    .txEn(txEn), .txBit(txBit), .pullDown(pullDownW),
    .rxBit(rxBit), .rxValid(rxValid), .frameStart(frameStart)
  );

  assign pullDown = pullDownW;

endmodule

// File: rtl/pwmSlaveChk.sv
module pwmSlaveChk
  import pwmSlavePkg::*;
#(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input slotStrb_t        strb,
  input logic [CNT_W-1:0] grayCnt,
  input logic             pullDown,
  input logic             rxValid,
  input logic             frameStart
);

  // R2: counter moves one bit at a time except on a slot restart
  a_r2_gray_step: assert property (@(posedge clk) disable iff (!rstN)
    !strb.slotStart |=> ($countones(grayCnt ^ $past(grayCnt)) <= 1));

  // R3: receive strobe lasts one cycle
  a_r3_rx_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R3: receive strobe never coincides with the frame strobe
  a_r3_rx_not_frame: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && frameStart));

  // R4: pull-down only turns on right after an accepted slot start
  a_r4_pull_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullDown) |-> $past(strb.slotStart));

  // R7: frame strobe lasts one cycle
  a_r7_frame_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R8: a slot start suppresses the frame strobe in the next cycle
  a_r8_start_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.slotStart |=> !frameStart);

endmodule

bind pwmSlave pwmSlaveChk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .grayCnt(grayCnt),
  .pullDown(pullDown), .rxValid(rxValid), .frameStart(frameStart)
);

// File: tb/tb_pwmSlave.sv
module tb_pwmSlave;

  localparam int D       = 4;           // TICK_DIV
  localparam int S       = 2;           // SAMPLE_AT
  localparam int CMAX    = 7;           // all-ones of a 3-bit counter
  localparam int SAMPLE  = S * D;       // cycles from slot start to sample
  localparam int TMO     = CMAX * D;    // cycles from slot start to timeout
  localparam int LAT     = 3;           // drive cycle to slot-start cycle

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic masterLow = 1'b0;
  logic forceHigh = 1'b0;
  logic txEn = 1'b0;
  logic txBit = 1'b0;
  logic lineIn;
  logic pullDown, rxBit, rxValid, frameStart;

  int cyc = 0;
  int rxCnt = 0, rxCyc = 0, frCnt = 0, frCyc = 0, pdCnt = 0;
  logic rxVal = 1'b0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign lineIn = forceHigh ? 1'b1 : !(masterLow || pullDown);

  pwmSlave #(.CNT_W(3), .TICK_DIV(D), .SAMPLE_AT(S)) dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .txEn(txEn), .txBit(txBit),
    .pullDown(pullDown), .rxBit(rxBit), .rxValid(rxValid),
    .frameStart(frameStart)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rxValid) begin rxCnt++; rxCyc = cyc; rxVal = rxBit; end
    if (frameStart) begin frCnt++; frCyc = cyc; end
    if (pullDown) pdCnt++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expRx(input int lowLen);
    return (lowLen < SAMPLE + 2) ? 1 : 0;
  endfunction

  function automatic int expPd(input bit isRead, input bit val);
    return (isRead && !val) ? SAMPLE : 0;
  endfunction

  function automatic int expFrames(input int gap);
    return (gap >= TMO + LAT + 1) ? 1 : 0;
  endfunction

  task automatic runSlot(input bit isRead, input bit val, input int gap,
                         input int lowLen, input bit flipTx, input bit glitch,
                         input string tag);
    int c, rx0, fr0, pd0;
    @(posedge clk); #2;
    c = cyc; rx0 = rxCnt; fr0 = frCnt; pd0 = pdCnt;
    txEn = isRead; txBit = val; masterLow = 1'b1;
    for (int i = 1; i < gap; i++) begin
      @(posedge clk); #2;
      if (i == lowLen) masterLow = 1'b0;
      if (flipTx && i == 5) begin txEn = ~txEn; txBit = ~txBit; end
      if (glitch && i == 4) forceHigh = 1'b1;
      if (glitch && i == 6) forceHigh = 1'b0;
    end
    @(negedge clk); #1;
    if (isRead) begin
      check(rxCnt - rx0 == 0, {tag, " read slot no rxValid"}, rxCnt - rx0, 0);
      check(pdCnt - pd0 == expPd(isRead, val), {tag, " pull-down length"},
            pdCnt - pd0, expPd(isRead, val));
    end else begin
      check(rxCnt - rx0 == 1, {tag, " R3 rxValid count"}, rxCnt - rx0, 1);
      check(rxCyc == c + LAT + SAMPLE, {tag, " R3 rxValid cycle"},
            rxCyc - c, LAT + SAMPLE);
      check(int'(rxVal) == expRx(lowLen), {tag, " R3 rxBit"}, rxVal, expRx(lowLen));
      check(pdCnt - pd0 == 0, {tag, " write slot no pull-down"}, pdCnt - pd0, 0);
    end
    check(frCnt - fr0 == expFrames(gap), {tag, " frameStart count"},
          frCnt - fr0, expFrames(gap));
    if (expFrames(gap) == 1)
      check(frCyc == c + LAT + TMO, {tag, " R7 frameStart cycle"},
            frCyc - c, LAT + TMO);
    txEn = 1'b0; txBit = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pullDown && !rxValid && !frameStart && !rxBit, "R1 in reset",
          {pullDown, rxValid, frameStart, rxBit}, 0);
    @(posedge clk); #2 rstN = 1'b1;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check(frCnt == 0 && rxCnt == 0 && pdCnt == 0, "R1 idle after reset",
          frCnt + rxCnt + pdCnt, 0);

    // directed corners
    runSlot(0, 0, 20, 3, 0, 0, "R2 write one");
    runSlot(0, 0, 20, 12, 0, 0, "R2 write zero");
    runSlot(1, 0, 20, 3, 0, 0, "R4");
    runSlot(1, 1, 20, 3, 0, 0, "R5");
    runSlot(1, 0, 20, 3, 1, 0, "R6 flip read0");
    runSlot(1, 1, 20, 3, 1, 0, "R6 flip read1");
    runSlot(0, 0, 20, 3, 1, 0, "R6 flip write");
    runSlot(1, 0, 40, 3, 0, 1, "R9 glitch");
    runSlot(0, 0, TMO, 3, 0, 0, "R8 collide");
    runSlot(0, 0, 20, 12, 0, 0, "R8 after collide");
    runSlot(0, 0, 90, 12, 0, 0, "R7 long idle");

    // constrained random slots
    for (int n = 0; n < 60; n++) begin
      bit isRead = 1'($urandom_range(1, 0));
      bit val    = 1'($urandom_range(1, 0));
      int gap    = ($urandom_range(9, 0) == 0) ? 40 : int'($urandom_range(26, 16));
      int lowLen = isRead ? 3 : (val ? int'($urandom_range(5, 2)) : int'($urandom_range(13, 11)));
      runSlot(isRead, val, gap, lowLen, 1'($urandom_range(1, 0)), 1'b0,
              isRead ? (val ? "R5 rnd" : "R4 rnd") : "R3 rnd");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule